// File: doc/BRIEF.md
# Dual-Channel Tamper Pin Detector

This block watches two external tamper pins, clocked by the real-time clock, and records a tamper event per channel when the configured condition appears on an enabled pin. A two-bit filter code picks the detection style for both channels. A zero code means edge detection on the synchronized pin. A nonzero code means level detection on samples taken by a shared prescaler. Each channel's polarity bit picks which edge or which level counts as active.

Each detected event sets a sticky per-channel flag that stays set until a clear pulse arrives for that channel. The set flags drive an interrupt request when interrupts are enabled. When timestamping on tamper is enabled, a one-cycle strobe asks an external timestamp unit to capture the time. That request does not depend on any general timestamp enable elsewhere in the chip. Timestamp storage, pin precharge and the bus interface belong to neighbouring blocks.

Top module: `tamper_detect`

## Requirements
- R1: While reset is held and after its release, with no pin activity, `tamper_flag`, `irq` and `ts_strobe` are all 0.
- R2: A channel whose `ch_en` bit is 0 never sets its flag, in edge mode or in level mode.
- R3: With `filt_sel` = 0, a channel with polarity 0 detects a rising pin edge and one with polarity 1 detects a falling edge. The opposite edge has no effect. The flag reads 1 after the third rising clock edge following the pin change, and not after the second.
- R4: With `filt_sel` = N (1 to 3), a channel fires once 2^N consecutive samples have shown the active level. The active level is low for polarity 0 and high for polarity 1.
- R5: In level mode, one sample at the inactive level restarts the consecutive-sample count from zero.
- R6: Both channels share one sample period of 2^(15-code) clocks for `rate_sel` codes 0 to 7 (32768 down to 256). Two channels that turn active together set their flags in the same cycle.
- R7: Any change of `rate_sel` restarts the prescaler, so the first sample at the new rate comes one full new period after the change.
- R8: A flag stays set until a one-cycle pulse on its own `flag_clr` bit. Clearing one channel leaves the other channel's flag unchanged.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one flag is set.
- R10: With `ts_en` = 1, `ts_strobe` pulses for one cycle, in the same cycle in which a flag first reads 1 after being clear. With `ts_en` = 0 there is no pulse.
- R11: A detected event and a clear on the same channel in the same cycle leave the flag set. A strobe follows only if the flag was clear before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 2 | Per-channel detection enable |
| ch_pol | input | 2 | Per-channel polarity: edge choice or level choice |
| filt_sel | input | 2 | 0 = edge mode, N = 2^N consecutive samples |
| rate_sel | input | 3 | Sample period code, 2^(15-code) clocks |
| irq_en | input | 1 | Interrupt enable |
| ts_en | input | 1 | Timestamp request on tamper enable |
| pin_in | input | 2 | Asynchronous tamper pins |
| flag_clr | input | 2 | Per-channel one-cycle flag clear |
| tamper_flag | output | 2 | Sticky per-channel tamper flags |
| irq | output | 1 | Interrupt request |
| ts_strobe | output | 1 | One-cycle timestamp capture request |

## Verification
A software clear of a flag and a fresh detection on the same channel can reach the flag register in the same clock cycle. The bench provokes this by timing a clear pulse into the cycle in which a synchronized edge is already visible, which is two clocks after the pin changes. It does this once with the flag previously clear and once with it already set. It judges that the flag survives in both cases, and that the timestamp strobe appears only in the first case.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  // Width of a level-mode run counter able to hold 2^(2^filt_w - 1).
  function automatic int run_cnt_width(input int filt_w);
    return (2 ** filt_w);
  endfunction

  // Polarity meaning in each mode.
  typedef enum logic {
    POL_RISE_OR_LOW  = 1'b0,
    POL_FALL_OR_HIGH = 1'b1
  } tamper_pol_e;

endpackage

// File: rtl/tamper_prescaler.sv
module tamper_prescaler #(
  parameter int MAX_LOG2 = 15,
  parameter int RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              sample_tick
);
  localparam int CNT_W = MAX_LOG2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W:0]    period;
  logic [CNT_W-1:0]  last_val;
  logic              rate_chg;

  always_comb begin
    period      = (CNT_W+1)'(1) << (MAX_LOG2 - int'(rate_sel));
    last_val    = CNT_W'(period - 1'b1);
    rate_chg    = (rate_sel != rate_q);
    sample_tick = !rate_chg && (cnt_q == last_val);
    if (rate_chg || sample_tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_sel;
    end
  end
endmodule

// File: rtl/tamper_channel.sv
module tamper_channel #(
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pol,
  input  logic [FILT_W-1:0] filt_sel,
  input  logic              sample_tick,
  input  logic              pin,
  output logic              hit
);
  import tamper_pkg::*;
  localparam int CNT_W = run_cnt_width(FILT_W);

  logic             sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] target, run_inc;
  logic             level_mode, active, edge_hit, level_hit;

  always_comb begin
    level_mode = (filt_sel != '0);
    active     = (sync2_q == pol);
    target     = CNT_W'(1) << filt_sel;
    run_inc    = run_q + 1'b1;
    edge_hit   = (pol == POL_FALL_OR_HIGH) ? (prev_q & ~sync2_q)
                                           : (sync2_q & ~prev_q);
    level_hit  = sample_tick && active && (run_inc >= target);

    if (!en || !level_mode)  run_d = '0;
    else if (sample_tick) begin
      if (!active)           run_d = '0;
      else if (run_q < target) run_d = run_inc;
      else                   run_d = run_q;
    end else                 run_d = run_q;

    hit = en && (level_mode ? level_hit : edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/tamper_flag_bank.sv
module tamper_flag_bank #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] clr,
  input  logic              irq_en,
  input  logic              ts_en,
  output logic [NUM_CH-1:0] flag,
  output logic              irq,
  output logic              ts_strobe
);
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              strobe_q, strobe_d;

  always_comb begin
    flag_d   = hit | (flag_q & ~clr);
    strobe_d = ts_en && |(hit & ~flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      strobe_q <= strobe_d;
    end
  end

  assign flag      = flag_q;
  assign ts_strobe = strobe_q;
  assign irq       = irq_en && (|flag_q);
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect #(
  parameter int NUM_CH   = 2,
  parameter int MAX_LOG2 = 15,
  parameter int RATE_W   = 3,
  parameter int FILT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_pol,
  input  logic [FILT_W-1:0] filt_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              ts_en,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [NUM_CH-1:0] flag_clr,
  output logic [NUM_CH-1:0] tamper_flag,
  output logic              irq,
  output logic              ts_strobe
);
  logic              sample_tick;
  logic [NUM_CH-1:0] ch_hit;

  tamper_prescaler #(.MAX_LOG2(MAX_LOG2), .RATE_W(RATE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .sample_tick(sample_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tamper_channel #(.FILT_W(FILT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(ch_en[g]), .pol(ch_pol[g]),
      .filt_sel(filt_sel), .sample_tick(sample_tick), .pin(pin_in[g]),
      .hit(ch_hit[g])
    );
  end

  tamper_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(ch_hit), .clr(flag_clr),
    .irq_en(irq_en), .ts_en(ts_en), .flag(tamper_flag),
    .irq(irq), .ts_strobe(ts_strobe)
  );
endmodule

// File: rtl/tamper_detect_chk.sv
module tamper_detect_chk #(
  parameter int NUM_CH = 2,
  parameter int RATE_W = 3,
  parameter int FILT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic [FILT_W-1:0] filt_sel,
  input logic [RATE_W-1:0] rate_sel,
  input logic              ts_en,
  input logic [NUM_CH-1:0] flag_clr,
  input logic [NUM_CH-1:0] tamper_flag,
  input logic              irq,
  input logic              ts_strobe,
  input logic              sample_tick
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tamper_flag[i]) |-> $past(ch_en[i]));
    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tamper_flag[i]) |-> $past(flag_clr[i]));
    assert_level_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tamper_flag[i]) && ($past(filt_sel) != '0)) |-> $past(sample_tick));
  end

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|tamper_flag));
  assert_strobe_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe |-> ($past(ts_en) && (|tamper_flag)));
  assert_rate_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != $past(rate_sel)) |-> !sample_tick);
endmodule

bind tamper_detect tamper_detect_chk #(.NUM_CH(NUM_CH), .RATE_W(RATE_W), .FILT_W(FILT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .filt_sel(filt_sel),
  .rate_sel(rate_sel), .ts_en(ts_en), .flag_clr(flag_clr),
  .tamper_flag(tamper_flag), .irq(irq), .ts_strobe(ts_strobe),
  .sample_tick(sample_tick)
);

// File: tb/tamper_detect_tb.sv
module tamper_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ch_en, ch_pol, filt_sel, pin_in, flag_clr, tamper_flag;
  logic [2:0] rate_sel;
  logic       irq_en, ts_en, irq, ts_strobe;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tamper_detect u_dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_pol(ch_pol),
    .filt_sel(filt_sel), .rate_sel(rate_sel), .irq_en(irq_en), .ts_en(ts_en),
    .pin_in(pin_in), .flag_clr(flag_clr), .tamper_flag(tamper_flag),
    .irq(irq), .ts_strobe(ts_strobe)
  );

  // Edge vectors: {ch, en, pol, pin_before, pin_after, expect}
  localparam logic [5:0] EDGE_VEC [10] = '{
    6'b0_1_0_0_1_1, 6'b0_1_0_1_0_0, 6'b0_1_1_1_0_1, 6'b0_1_1_0_1_0, 6'b0_0_0_0_1_0,
    6'b1_1_0_0_1_1, 6'b1_1_0_1_0_0, 6'b1_1_1_1_0_1, 6'b1_1_1_0_1_0, 6'b1_0_0_0_1_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = 2'b11; step(1); flag_clr = 2'b00; step(1);
  endtask

  // Level-mode run on both channels: flags must be clear at lo, set at hi.
  task automatic level_run(input logic [1:0] n, input logic [2:0] code,
                           input logic pol, input int lo, input int hi, input string req);
    filt_sel = 2'd0; ch_pol = {pol, pol}; pin_in = {~pol, ~pol}; ch_en = 2'b11;
    step(4); clear_all();
    rate_sel = code; filt_sel = n; step(3);
    pin_in = {pol, pol};
    step(lo);  chk(req, tamper_flag, 0);
    step(hi - lo); chk(req, tamper_flag, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ch_en = 0; ch_pol = 0; filt_sel = 0; rate_sel = 3'd7;
    irq_en = 1'b1; ts_en = 1'b1; pin_in = 0; flag_clr = 0;
    step(3);
    chk("R1 flags in reset", tamper_flag, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1; step(5);
    chk("R1 flags after reset", tamper_flag, 0);
    chk("R1 strobe after reset", ts_strobe, 0);

    // Table walk: edge mode, R2 and R3, plus R9/R10 on the same vectors.
    for (int v = 0; v < 10; v++) begin
      automatic int c = EDGE_VEC[v][5];
      ch_en = 0; filt_sel = 0;
      ch_pol[c] = EDGE_VEC[v][3];
      pin_in[c] = EDGE_VEC[v][2];
      step(5);
      ch_en[c] = EDGE_VEC[v][4];
      clear_all();
      pin_in[c] = EDGE_VEC[v][1];
      step(2);
      chk("R3 not yet after two clocks", tamper_flag, 0);
      step(1);
      chk("R2/R3 edge vector flag", tamper_flag, EDGE_VEC[v][0] << c);
      chk("R10 strobe on first set", ts_strobe, EDGE_VEC[v][0]);
      chk("R9 irq follows flag", irq, EDGE_VEC[v][0]);
      step(1);
      chk("R10 strobe one cycle", ts_strobe, 0);
    end

    // R8: per-channel clear, flags sticky.
    ch_en = 2'b11; ch_pol = 2'b00; filt_sel = 0; pin_in = 0; step(4); clear_all();
    pin_in = 2'b11; step(4);
    chk("R8 both set", tamper_flag, 3);
    pin_in = 2'b00; step(10);
    chk("R8 sticky after pin drops", tamper_flag, 3);
    flag_clr = 2'b01; step(1); flag_clr = 0; step(1);
    chk("R8 clear ch0 only", tamper_flag, 2);

    // R9: interrupt gating.
    irq_en = 1'b0; step(1);
    chk("R9 irq masked", irq, 0);
    irq_en = 1'b1; step(1);
    chk("R9 irq unmasked", irq, 1);
    clear_all();
    chk("R9 irq drops with flags", irq, 0);

    // R10: no strobe with ts_en low.
    ts_en = 1'b0; pin_in = 2'b01; step(3);
    chk("R10 flag without ts", tamper_flag, 1);
    chk("R10 no strobe when disabled", ts_strobe, 0);
    ts_en = 1'b1; pin_in = 0; step(4); clear_all();

    // R11: clear and detection in the same cycle.
    pin_in = 2'b01; step(2);
    flag_clr = 2'b01; step(1); flag_clr = 0;
    chk("R11 set beats clear (was clear)", tamper_flag, 1);
    chk("R11 strobe when was clear", ts_strobe, 1);
    pin_in = 0; step(4);
    pin_in = 2'b01; step(2);
    flag_clr = 2'b01; step(1); flag_clr = 0;
    chk("R11 set beats clear (was set)", tamper_flag, 1);
    chk("R11 no strobe when was set", ts_strobe, 0);
    flag_clr = 2'b01; step(1); flag_clr = 0; step(1);
    chk("R8 lone clear empties flag", tamper_flag, 0);
    pin_in = 0;

    // R4/R6: level mode windows, P = 2^(15-code).
    level_run(2'd1, 3'd7, 1'b1, 256, 3 * 256 + 10, "R4 two samples high");
    level_run(2'd2, 3'd7, 1'b1, 768, 5 * 256 + 10, "R4 four samples high");
    level_run(2'd3, 3'd7, 1'b1, 1792, 9 * 256 + 10, "R4 eight samples high");
    level_run(2'd1, 3'd6, 1'b0, 512, 3 * 512 + 10, "R6 rate 6 low level both channels");

    // R2 in level mode: disabled channel holds off.
    filt_sel = 0; ch_en = 2'b01; ch_pol = 2'b11; pin_in = 0; step(4); clear_all();
    rate_sel = 3'd7; filt_sel = 2'd1; pin_in = 2'b11; step(1000);
    chk("R2 disabled channel in level mode", tamper_flag, 1);

    // R5: an inactive sample restarts the run.
    filt_sel = 0; ch_en = 2'b01; pin_in = 0; step(4); clear_all();
    filt_sel = 2'd2; step(3);
    pin_in = 2'b01; step(640);
    chk("R5 run not complete", tamper_flag, 0);
    pin_in = 0; step(300);
    pin_in = 2'b01; step(700);
    chk("R5 count restarted after glitch", tamper_flag, 0);
    step(600);
    chk("R5 fires after fresh run", tamper_flag, 1);

    // R7: rate change restarts the prescaler.
    filt_sel = 0; pin_in = 0; step(4); clear_all();
    filt_sel = 2'd1; rate_sel = 3'd0; step(1); rate_sel = 3'd7; step(300);
    rate_sel = 3'd6; pin_in = 2'b01;
    step(1010);
    chk("R7 no early sample after rate change", tamper_flag, 0);
    step(20);
    chk("R7 sample one full period later", tamper_flag, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule